// File: doc/BRIEF.md
# Receive Drop Statistics Word

This block keeps two event counters for a receive path and presents them, with a sticky overflow flag for each, in one 32-bit read word. One counter records frames lost when the receive FIFO overflowed. The other records frames thrown away by the DMA because no host receive buffer was free. Each counter advances by one for every cycle in which its event pulse is high. When a counter has reached its all-ones value, it stays there and raises its flag instead of wrapping.

The host reads the word through a read strobe qualified by four byte-lane enables. The read data is always the current state. A read clears only the fields whose controlling lane is enabled, so software can collect one statistic without losing the other. If an event arrives in the same cycle as a clearing read, the read returns the value from before the event, and the counter restarts at one.

Top module: `rx_drop_stats`

## Requirements
- R1: After reset, every bit of `rd_data` is 0.
- R2: `rd_data[27:17]` holds an 11-bit count that goes up by one at each clock edge where `fifo_ovf_evt` is 1.
- R3: `rd_data[15:0]` holds a 16-bit count that goes up by one at each clock edge where `buf_miss_evt` is 1.
- R4: An event that arrives while its count is all ones leaves the count at all ones and sets its flag: `rd_data[28]` for the FIFO count, `rd_data[16]` for the buffer count. A flag stays set until it is cleared.
- R5: A cycle with `rd_stb`=1 and `rd_be[2]`=1 clears `rd_data[28:17]` at the next edge.
- R6: A cycle with `rd_stb`=1 and `rd_be[0]`=1 clears `rd_data[16:0]` at the next edge.
- R7: A read whose controlling lane bit is 0 leaves that count and its flag unchanged. `rd_be[1]` and `rd_be[3]` clear nothing.
- R8: If an event and a clearing read for the same counter fall in one cycle, `rd_data` in that cycle shows the old value. After the edge the count is 1 and the flag is 0.
- R9: `rd_data[31:29]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_ovf_evt | input | 1 | One count per cycle high: frame lost to FIFO overflow |
| buf_miss_evt | input | 1 | One count per cycle high: frame discarded because no host buffer was free |
| rd_stb | input | 1 | Read strobe for the statistics word |
| rd_be | input | 4 | Byte-lane enables qualifying the read |
| rd_data | output | 32 | Current statistics word |

## Verification
The hardest conditions to reach are the flag states, because each needs its counter driven all the way to all ones. The stimulus streams 2050 FIFO events and then 65540 buffer events back to back. At saturation it tries reads on the wrong lane, a clearing read, and a clearing read that coincides with an event. A scoreboard model, built from the requirements, predicts the word in every checked cycle.

// File: rtl/rx_drop_stats_pkg.sv
package rx_drop_stats_pkg;
    localparam int FIFO_CNT_W    = 11;
    localparam int BUF_CNT_W     = 16;
    localparam int WORD_W        = 32;
    localparam int BE_W          = WORD_W / 8;
    localparam int FIFO_CLR_LANE = 2;
    localparam int BUF_CLR_LANE  = 0;
    localparam int BUF_CNT_LSB   = 0;
    localparam int BUF_FLG_POS   = BUF_CNT_LSB + BUF_CNT_W;
    localparam int FIFO_CNT_LSB  = BUF_FLG_POS + 1;
    localparam int FIFO_FLG_POS  = FIFO_CNT_LSB + FIFO_CNT_W;
    localparam int USED_W        = FIFO_FLG_POS + 1;
    localparam int RSVD_W        = WORD_W - USED_W;
endpackage

// File: rtl/drop_sat_counter.sv
module drop_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = inc ? CNT_ONE : '0;
            st_d.ovf = 1'b0;
        end else if (inc) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr && cnt != CNT_MAX |=> cnt == $past(cnt) + CNT_ONE); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr && cnt == CNT_MAX |=> cnt == CNT_MAX && ovf); // R4
    AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf); // R4
    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr && inc |=> cnt == CNT_ONE && !ovf); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !inc |=> $stable(cnt) && $stable(ovf)); // R7
endmodule

// File: rtl/rx_drop_stats.sv
module rx_drop_stats
    import rx_drop_stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_ovf_evt,
    input  logic              buf_miss_evt,
    input  logic              rd_stb,
    input  logic [BE_W-1:0]   rd_be,
    output logic [WORD_W-1:0] rd_data
);
    logic                  fifo_clr, buf_clr;
    logic [FIFO_CNT_W-1:0] fifo_cnt;
    logic [BUF_CNT_W-1:0]  buf_cnt;
    logic                  fifo_flg, buf_flg;

    assign fifo_clr = rd_stb & rd_be[FIFO_CLR_LANE];
    assign buf_clr  = rd_stb & rd_be[BUF_CLR_LANE];

    drop_sat_counter #(.W(FIFO_CNT_W)) u_fifo_cnt (
        .clk(clk), .rst_n(rst_n), .inc(fifo_ovf_evt), .clr(fifo_clr),
        .cnt(fifo_cnt), .ovf(fifo_flg)
    );

    drop_sat_counter #(.W(BUF_CNT_W)) u_buf_cnt (
        .clk(clk), .rst_n(rst_n), .inc(buf_miss_evt), .clr(buf_clr),
        .cnt(buf_cnt), .ovf(buf_flg)
    );

    always_comb begin
        rd_data = '0;
        rd_data[BUF_CNT_LSB +: BUF_CNT_W]   = buf_cnt;
        rd_data[BUF_FLG_POS]                = buf_flg;
        rd_data[FIFO_CNT_LSB +: FIFO_CNT_W] = fifo_cnt;
        rd_data[FIFO_FLG_POS]               = fifo_flg;
    end

    AST_FIFO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && rd_be[FIFO_CLR_LANE] && !fifo_ovf_evt
        |=> rd_data[FIFO_FLG_POS:FIFO_CNT_LSB] == '0); // R5
    AST_BUF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && rd_be[BUF_CLR_LANE] && !buf_miss_evt
        |=> rd_data[BUF_FLG_POS:BUF_CNT_LSB] == '0); // R6
    AST_FIFO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_be[FIFO_CLR_LANE] && !fifo_ovf_evt
        |=> $stable(rd_data[FIFO_FLG_POS:FIFO_CNT_LSB])); // R7
    AST_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_be[BUF_CLR_LANE] && !buf_miss_evt
        |=> $stable(rd_data[BUF_FLG_POS:BUF_CNT_LSB])); // R7
endmodule

// File: tb/rx_drop_stats_test.sv
module rx_drop_stats_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_ovf_evt = 1'b0;
    logic        buf_miss_evt = 1'b0;
    logic        rd_stb = 1'b0;
    logic [3:0]  rd_be = 4'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [10:0] m_fcnt = '0;
    logic        m_fflg = 1'b0;
    logic [15:0] m_bcnt = '0;
    logic        m_bflg = 1'b0;

    always #10 clk = ~clk;

    rx_drop_stats uut (
        .clk(clk), .rst_n(rst_n), .fifo_ovf_evt(fifo_ovf_evt),
        .buf_miss_evt(buf_miss_evt), .rd_stb(rd_stb), .rd_be(rd_be),
        .rd_data(rd_data)
    );

    function automatic logic [31:0] model_word();
        return {3'b000, m_fflg, m_fcnt, m_bflg, m_bcnt};
    endfunction

    // One clock cycle of stimulus; optionally expects the word seen during it.
    task automatic step(input bit fe, input bit be_evt, input bit stb,
                        input logic [3:0] be, input bit chk, input string tag);
        @(negedge clk);
        fifo_ovf_evt = fe;
        buf_miss_evt = be_evt;
        rd_stb       = stb;
        rd_be        = be;
        #2;
        if (chk) begin
            exp_q.push_back(model_word());
            tag_q.push_back(tag);
        end
        if (stb && be[2]) begin
            m_fcnt = fe ? 11'd1 : 11'd0;
            m_fflg = 1'b0;
        end else if (fe) begin
            if (m_fcnt == 11'h7FF) m_fflg = 1'b1;
            else m_fcnt = m_fcnt + 11'd1;
        end
        if (stb && be[0]) begin
            m_bcnt = be_evt ? 16'd1 : 16'd0;
            m_bflg = 1'b0;
        end else if (be_evt) begin
            if (m_bcnt == 16'hFFFF) m_bflg = 1'b1;
            else m_bcnt = m_bcnt + 16'd1;
        end
    endtask

    // Monitor: compares the word in the same cycle the expectation was queued.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() != 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: timeout reached, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 4'h0, 1, "R1");
        // R2 / R3 / R9 basic counting, mixed patterns
        for (int i = 0; i < 5; i++) step(1, 0, 0, 4'h0, 0, "");
        step(0, 0, 0, 4'h0, 1, "R2");
        for (int i = 0; i < 7; i++) step(0, 1, 0, 4'h0, 0, "");
        step(0, 0, 0, 4'h0, 1, "R3");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 4'h0, 0, "");
        step(0, 0, 0, 4'h0, 1, "R9");
        // R7 reads on unrelated lanes, and enables without strobe
        step(0, 0, 1, 4'b1010, 1, "R7");
        step(0, 0, 0, 4'hF, 1, "R7");
        step(0, 0, 0, 4'h0, 1, "R7");
        // R5 clear FIFO count only
        step(0, 0, 1, 4'b0100, 1, "R5");
        step(0, 0, 0, 4'h0, 1, "R5");
        // R6 clear buffer count only
        step(1, 0, 0, 4'h0, 0, "");
        step(0, 0, 1, 4'b0001, 1, "R6");
        step(0, 0, 0, 4'h0, 1, "R6");
        // R8 event with clearing read in one cycle
        for (int i = 0; i < 4; i++) step(0, 1, 0, 4'h0, 0, "");
        step(0, 1, 1, 4'b0001, 1, "R8");
        step(0, 0, 0, 4'h0, 1, "R8");
        step(1, 0, 1, 4'b0100, 1, "R8");
        step(0, 0, 0, 4'h0, 1, "R8");
        // R4 saturate FIFO counter
        for (int i = 0; i < 2050; i++) step(1, 0, 0, 4'h0, 0, "");
        step(0, 0, 0, 4'h0, 1, "R4");
        step(0, 0, 1, 4'b1011, 1, "R7");
        step(1, 0, 0, 4'h0, 1, "R4");
        step(0, 0, 1, 4'b0100, 1, "R5");
        step(0, 0, 0, 4'h0, 1, "R5");
        // R4 saturate buffer counter
        for (int i = 0; i < 65540; i++) step(0, 1, 0, 4'h0, 0, "");
        step(0, 0, 0, 4'h0, 1, "R4");
        step(0, 0, 1, 4'b1110, 1, "R7");
        step(0, 1, 1, 4'b0001, 1, "R8");
        step(0, 0, 0, 4'h0, 1, "R8");
        step(0, 0, 0, 4'h0, 1, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule